// File: doc/BRIEF.md
# Synthesizer Programming Register Bank

This block is the control front end of a fractional/integer frequency synthesizer. Software shifts 24-bit words into it over a three-wire serial port made of a serial clock, a data line and a load strobe. The three lowest bits of each word are an address. When the load strobe rises, the whole word is copied into the control register that the address selects. The registers then drive the control lines of the analog and divider sections:

- counter hold
- charge-pump high-impedance
- bias power-down
- lock-detector clear
- output multiplexer select
- phase-detector polarity
- RF test code
- IF charge-pump current
- IF divider words

All three serial lines are brought into the system clock domain through synchronizers and sampled there on their edges. The serial port keeps working in every state of the block.

A power-down sequencer is a state machine with five states:

- `ST_RUN`: normal operation.
- `ST_QUIESCE`: the charge pumps are isolated.
- `ST_FREEZE`: the counters are also held and the lock detector is cleared.
- `ST_SLEEP`: bias is also removed.
- `ST_WAKE`: bias is restored while the counters stay held for one cycle.

It has five transitions:

- `run_to_quiesce`: taken when the power-down bit is set.
- `quiesce_to_freeze`: unconditional.
- `freeze_to_sleep`: unconditional.
- `sleep_to_wake`: taken when the power-down bit is clear.
- `wake_to_run`: unconditional.

Top module: `synth_regbank`

## Requirements
- R1: Serial data is taken MSB first on each rising serial clock, and the last 24 bits are transferred on the rising load strobe. Word bits [2:0] select the target register: 010 RF control, 011 master, 100 IF divide-N, 101 IF divide-R, 110 IF control.
- R2: After hardware reset, every register is zero. All outputs are then low or zero, including `mux_valid` and `mux_sel`.
- R3: Master bit 3 drives `cnt_reset` and master bit 4 drives `cp_hiz`, each while set.
- R4: A master write sets `mux_valid`. While `mux_valid` is 1, `mux_sel` equals master bits [10:7].
- R5: A write to the RF control register (010) or to the IF control register (110) clears `mux_valid`, and `mux_sel` then reads 0. Both stay that way until the master register is written again.
- R6: Master bit 5 starts the power-down sequence, which moves one state per clock. `cp_hiz` rises first. `cnt_reset` and `lock_clr` rise one clock later. `pwr_down` rises one clock after that. On exit, `pwr_down` falls one clock before `cnt_reset` and `cp_hiz` fall.
- R7: During power-down the serial port still loads words, and every register keeps its contents.
- R8: RF control bit 7 drives `pd_polarity` (1 for a positive oscillator slope). RF control bits [13:11] drive `rf_test_mode`, where 000 is normal operation.
- R9: While master bit 6 is set, `if_cp_current` is 3'b111. When the bit is cleared, `if_cp_current` returns to IF control bits [5:3].
- R10: Words addressed to 000, 001 or 111 change no register and no output.
- R11: `ifn_data` and `ifr_data` present bits [23:3] of the last IF divide-N and IF divide-R words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, MSB first |
| sle | input | 1 | Load strobe, transfers word on rising edge |
| cnt_reset | output | 1 | Hold for RF and IF divider counters |
| cp_hiz | output | 1 | Both charge pumps high-impedance |
| pwr_down | output | 1 | Bias and oscillator buffer disable |
| lock_clr | output | 1 | Lock-detector clear |
| mux_valid | output | 1 | Multiplexer selection currently valid |
| mux_sel | output | 4 | Output multiplexer source select |
| pd_polarity | output | 1 | Phase-detector polarity |
| rf_test_mode | output | 3 | RF test code |
| if_cp_current | output | 3 | Effective IF charge-pump current code |
| ifn_data | output | 21 | IF divide-N word payload |
| ifr_data | output | 21 | IF divide-R word payload |

## Verification
If a register latches the wrong word or misses a decode, the fault appears on that register's control outputs a few clocks after the load strobe rises. It stays there until the next write to that register.

If the multiplexer-validity flag is lost, `mux_sel` reads zero or a stale value right after an RF or IF control write. If the sequencer sits in a wrong state, the order in which `cp_hiz`, `cnt_reset`, `lock_clr` and `pwr_down` rise and fall is broken within one to three clocks of the power-down bit changing.

// File: rtl/synth_regbank_pkg.sv
package synth_regbank_pkg;

    localparam int WORD_W = 24;
    localparam int ADDR_W = 3;
    localparam int DATA_W = WORD_W - ADDR_W;
    localparam int MUX_W  = 4;
    localparam int CUR_W  = 3;
    localparam int TST_W  = 3;

    localparam logic [ADDR_W-1:0] A_RFCTL  = 3'b010;
    localparam logic [ADDR_W-1:0] A_MASTER = 3'b011;
    localparam logic [ADDR_W-1:0] A_IFN    = 3'b100;
    localparam logic [ADDR_W-1:0] A_IFR    = 3'b101;
    localparam logic [ADDR_W-1:0] A_IFCTL  = 3'b110;

    localparam int B_CNTRST = 3;
    localparam int B_HIZ    = 4;
    localparam int B_PDN    = 5;
    localparam int B_GAIN   = 6;
    localparam int B_MUXLO  = 7;
    localparam int B_POL    = 7;
    localparam int B_TSTLO  = 11;
    localparam int B_CURLO  = 3;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_QUIESCE,
        ST_FREEZE,
        ST_SLEEP,
        ST_WAKE
    } pd_state_t;

endpackage

// File: rtl/serial_shifter.sv
module serial_shifter
    import synth_regbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              sle,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_word
);
    localparam int NLINES = 3;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;
    logic [WORD_W-1:0] shreg;

    assign raw = {sle, sdata, sclk};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev    <= '0;
            shreg   <= '0;
            wr_en   <= 1'b0;
            wr_word <= '0;
        end else begin
            prev  <= synced;
            wr_en <= 1'b0;
            if (synced[0] && !prev[0])
                shreg <= {shreg[WORD_W-2:0], synced[1]};
            if (synced[2] && !prev[2]) begin
                wr_en   <= 1'b1;
                wr_word <= shreg;
            end
        end
    end
endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile
    import synth_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] master_q,
    output logic [WORD_W-1:0] rfctl_q,
    output logic [WORD_W-1:0] ifn_q,
    output logic [WORD_W-1:0] ifr_q,
    output logic [WORD_W-1:0] ifctl_q,
    output logic              mux_ok
);
    logic [ADDR_W-1:0] addr;
    assign addr = wr_word[ADDR_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= '0;
            rfctl_q  <= '0;
            ifn_q    <= '0;
            ifr_q    <= '0;
            ifctl_q  <= '0;
            mux_ok   <= 1'b0;
        end else if (wr_en) begin
            unique case (addr)
                A_MASTER: begin master_q <= wr_word; mux_ok <= 1'b1; end
                A_RFCTL:  begin rfctl_q  <= wr_word; mux_ok <= 1'b0; end
                A_IFCTL:  begin ifctl_q  <= wr_word; mux_ok <= 1'b0; end
                A_IFN:    ifn_q <= wr_word;
                A_IFR:    ifr_q <= wr_word;
                default:  ;
            endcase
        end
    end

    p_mux_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MASTER) |=> mux_ok);
    p_mux_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_RFCTL || addr == A_IFCTL)) |=> !mux_ok);
    p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 3'b000 || addr == 3'b001 || addr == 3'b111)) |=>
        ($stable(master_q) && $stable(rfctl_q) && $stable(ifn_q) &&
         $stable(ifr_q) && $stable(ifctl_q) && $stable(mux_ok)));
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
    import synth_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    output logic seq_hiz,
    output logic seq_cnt,
    output logic lock_clr,
    output logic pwr_down
);
    pd_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (pd_req)  state_d = ST_QUIESCE;  // run_to_quiesce
            ST_QUIESCE:              state_d = ST_FREEZE;   // quiesce_to_freeze
            ST_FREEZE:               state_d = ST_SLEEP;    // freeze_to_sleep
            ST_SLEEP:   if (!pd_req) state_d = ST_WAKE;     // sleep_to_wake
            ST_WAKE:                 state_d = ST_RUN;      // wake_to_run
            default:                 state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        seq_hiz  = 1'b0;
        seq_cnt  = 1'b0;
        lock_clr = 1'b0;
        pwr_down = 1'b0;
        unique case (state_q)
            ST_RUN:     ;
            ST_QUIESCE: seq_hiz = 1'b1;
            ST_FREEZE:  begin seq_hiz = 1'b1; seq_cnt = 1'b1; lock_clr = 1'b1; end
            ST_SLEEP:   begin seq_hiz = 1'b1; seq_cnt = 1'b1; lock_clr = 1'b1;
                              pwr_down = 1'b1; end
            ST_WAKE:    begin seq_hiz = 1'b1; seq_cnt = 1'b1; end
            default:    ;
        endcase
    end

    p_hiz_before_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_clr) |-> $past(seq_hiz));
    p_freeze_before_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> ($past(lock_clr) && $past(seq_cnt)));
    p_wake_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down) |-> (seq_cnt && seq_hiz && $past(!pd_req)));
endmodule

// File: rtl/synth_regbank.sv
module synth_regbank
    import synth_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              sle,
    output logic              cnt_reset,
    output logic              cp_hiz,
    output logic              pwr_down,
    output logic              lock_clr,
    output logic              mux_valid,
    output logic [MUX_W-1:0]  mux_sel,
    output logic              pd_polarity,
    output logic [TST_W-1:0]  rf_test_mode,
    output logic [CUR_W-1:0]  if_cp_current,
    output logic [DATA_W-1:0] ifn_data,
    output logic [DATA_W-1:0] ifr_data
);
    logic              wr_en;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] master_q, rfctl_q, ifn_q, ifr_q, ifctl_q;
    logic              mux_ok;
    logic              seq_hiz, seq_cnt;

    serial_shifter #(.SYNC_STAGES(2)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sle(sle),
        .wr_en(wr_en), .wr_word(wr_word)
    );

    ctrl_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .master_q(master_q), .rfctl_q(rfctl_q), .ifn_q(ifn_q),
        .ifr_q(ifr_q), .ifctl_q(ifctl_q), .mux_ok(mux_ok)
    );

    pd_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .pd_req(master_q[B_PDN]),
        .seq_hiz(seq_hiz), .seq_cnt(seq_cnt), .lock_clr(lock_clr),
        .pwr_down(pwr_down)
    );

    assign cnt_reset     = master_q[B_CNTRST] | seq_cnt;
    assign cp_hiz        = master_q[B_HIZ] | seq_hiz;
    assign mux_valid     = mux_ok;
    assign mux_sel       = mux_ok ? master_q[B_MUXLO +: MUX_W] : '0;
    assign pd_polarity   = rfctl_q[B_POL];
    assign rf_test_mode  = rfctl_q[B_TSTLO +: TST_W];
    assign if_cp_current = master_q[B_GAIN] ? {CUR_W{1'b1}} : ifctl_q[B_CURLO +: CUR_W];
    assign ifn_data      = ifn_q[WORD_W-1:ADDR_W];
    assign ifr_data      = ifr_q[WORD_W-1:ADDR_W];
endmodule

// File: tb/synth_regbank_tb_top.sv
module synth_regbank_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
    logic cnt_reset, cp_hiz, pwr_down, lock_clr, mux_valid, pd_polarity;
    logic [3:0]  mux_sel;
    logic [2:0]  rf_test_mode, if_cp_current;
    logic [20:0] ifn_data, ifr_data;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    synth_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sle(sle),
        .cnt_reset(cnt_reset), .cp_hiz(cp_hiz), .pwr_down(pwr_down),
        .lock_clr(lock_clr), .mux_valid(mux_valid), .mux_sel(mux_sel),
        .pd_polarity(pd_polarity), .rf_test_mode(rf_test_mode),
        .if_cp_current(if_cp_current), .ifn_data(ifn_data), .ifr_data(ifr_data)
    );

    // {word, pwr_down, mux_valid, mux_sel[3:0], cp_hiz, cnt_reset, pd_polarity, if_cp_current[2:0]}
    localparam logic [35:0] VEC [0:6] = '{
        {24'h000283, 12'h540},
        {24'h000016, 12'h002},
        {24'h0004C3, 12'h647},
        {24'h000082, 12'h00F},
        {24'h00009B, 12'h47A},
        {24'hFFFFFF, 12'h47A},
        {24'h000003, 12'h40A}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) begin
            @(negedge clk); sdata = w[i]; sclk = 1'b0;
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            repeat (3) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (3) @(negedge clk);
        sle = 1'b1;
        repeat (4) @(negedge clk);
        sle = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    function automatic logic [11:0] snap();
        return {pwr_down, mux_valid, mux_sel, cp_hiz, cnt_reset, pd_polarity, if_cp_current};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R2 reset state
        check("R2", {20'd0, snap()}, 32'h0);
        check("R2 lock_clr", lock_clr, 0);
        check("R2 ifn", ifn_data, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R3 R4 R5 R8 R9 R10: table walk
        for (int v = 0; v < 7; v++) begin
            send_word(VEC[v][35:12]);
            check($sformatf("R1/R3/R4/R5/R8/R9/R10 vec%0d", v), {20'd0, snap()}, {20'd0, VEC[v][11:0]});
        end

        // R11 R1 divider payloads, MSB-first order
        send_word(24'hABCDEC);
        check("R11 ifn", ifn_data, 21'h1579BD);
        send_word(24'h123455);
        check("R11 ifr", ifr_data, 21'h2468A);

        // R8 test code and R5 drop on RF control
        send_word(24'h000283);
        send_word(24'h002802);
        check("R8 test", rf_test_mode, 3'b101);
        check("R8 pol", pd_polarity, 0);
        check("R5 mux_valid", mux_valid, 0);
        check("R5 mux_sel", mux_sel, 0);

        // R6 power-down sequence
        send_word(24'h000223);
        check("R6 pwr_down", pwr_down, 1);
        check("R6 cp_hiz", cp_hiz, 1);
        check("R6 cnt_reset", cnt_reset, 1);
        check("R6 lock_clr", lock_clr, 1);
        check("R7 mux kept", mux_sel, 4'd4);
        // R7 serial port alive while asleep
        send_word(24'h00000C);
        check("R7 ifn in sleep", ifn_data, 21'h1);
        check("R7 still asleep", pwr_down, 1);
        send_word(24'h000203);
        check("R6 exit pwr_down", pwr_down, 0);
        check("R6 exit cp_hiz", cp_hiz, 0);
        check("R6 exit cnt_reset", cnt_reset, 0);
        check("R6 exit lock_clr", lock_clr, 0);
        check("R7 test kept", rf_test_mode, 3'b101);

        // R10 unused addresses 000 and 001
        send_word(24'hFFFFF8);
        send_word(24'hFFFFF9);
        check("R10 ifn", ifn_data, 21'h1);
        check("R10 ifr", ifr_data, 21'h2468A);
        check("R10 mux", mux_sel, 4'd4);
        check("R10 hiz", cp_hiz, 0);

        // R9 gain override set then cleared restores IF control value
        send_word(24'h000036);
        send_word(24'h000043);
        check("R9 max", if_cp_current, 3'b111);
        send_word(24'h000003);
        check("R9 restore", if_cp_current, 3'b110);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule